// File: doc/BRIEF.md
# Display FIFO Priority Request Controller

This block sits beside a display pixel FIFO of 64-bit entries and decides when, and how urgently, the FIFO should ask a memory arbiter for more data. It keeps its own occupancy count from the push and pop strobes of the FIFO. It asks for a normal fill while there is room for a burst. When the FIFO drains dangerously low, it flags the request as urgent.

Urgency uses hysteresis. Two 4-bit threshold fields are given in units of four entries. The urgent state is entered once the occupancy is at or below the lower threshold. It is left only when the occupancy climbs to the upper threshold. Inconsistent thresholds raise a configuration error and urgency is withheld. A load-enable input freezes the count, silences all requests and clears the urgent state.

Top module: `dfp_prio_ctrl`

## Requirements
- R1: While rst_n is low the occupancy count is cleared to zero and high_pri is 0; req is 0 whenever load_en is 0.
- R2: On each rising clock edge with load_en high, the count rises by one for push alone and falls by one for pop alone. With both strobes it stays the same, except at 0, where it rises by one, and at 64, where it falls by one.
- R3: A push at a count of 64 is ignored, and a pop at a count of 0 is ignored; the count never leaves 0..64.
- R4: req equals load_en AND (high_pri OR count < 60), where 60 is the 64-entry depth minus a 4-entry burst.
- R5: Let the thresholds be valid and load_en high. If the urgent state is clear and the count is at most 4*start_lvl at a clock edge, high_pri is 1 after that edge.
- R6: If the urgent state is set and the count is at least 4*end_lvl at a clock edge, high_pri is 0 after that edge. Between the two levels the state is held.
- R7: cfg_err is 1, combinationally, when start_lvl is 0, end_lvl is 0, or start_lvl >= end_lvl. While cfg_err is 1, high_pri is 0 and the urgent state is cleared at the next edge.
- R8: While load_en is 0, push and pop do not change the count, high_pri is 0, and the urgent state is cleared at the next edge. After re-enabling, the block starts from the non-urgent state with the count it had before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | FIFO load enable; 0 freezes the count and silences requests |
| push | input | 1 | One entry written into the FIFO this cycle |
| pop | input | 1 | One entry read from the FIFO this cycle |
| start_lvl | input | 4 | Urgent-start threshold, in units of 4 entries |
| end_lvl | input | 4 | Urgent-end threshold, in units of 4 entries |
| req | output | 1 | Fill request to the memory arbiter |
| high_pri | output | 1 | Marks the current request as high priority |
| cfg_err | output | 1 | Threshold fields are inconsistent |

## Verification
The bench drives the count across both thresholds in both directions. It then reverses direction between them, which catches a design without hysteresis: such a design would drop or raise urgency at the wrong crossing. It pushes past 64 and pops below 0, and applies simultaneous strobes at both extremes, where a naive counter would wrap or miscount. It turns load_en off while urgent and keeps pushing. After re-enabling, a design that kept counting or kept its urgent state shows a wrong req or high_pri. It also walks each illegal threshold case, where a missing check would leave high_pri asserted.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

   typedef enum logic {
      URG_OFF = 1'b0,
      URG_ON  = 1'b1
   } urg_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned log2_exact(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/dfp_level_ctr.sv
module dfp_level_ctr #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             push,
   input  logic             pop,
   output logic [CNT_W-1:0] level
);

   localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);

   logic do_push;
   logic do_pop;

   if (DEPTH < 2) begin : g_bad_depth
      $error("dfp_level_ctr: DEPTH must be at least 2");
   end

   always_comb begin
      do_push = en && push && (level != FULL_V);
      do_pop  = en && pop  && (level != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= '0;
      end else if (do_push && !do_pop) begin
         level <= level + 1'b1;
      end else if (do_pop && !do_push) begin
         level <= level - 1'b1;
      end
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_V);

   a_r8_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> level == $past(level));

   a_r3_full_push_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (level == FULL_V) |=> level <= FULL_V);

endmodule

// File: rtl/dfp_thresh.sv
module dfp_thresh #(
   parameter int unsigned LVL_W = 4,
   parameter int unsigned UNIT  = 4,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [LVL_W-1:0] start_lvl,
   input  logic [LVL_W-1:0] end_lvl,
   output logic [CNT_W-1:0] start_ent,
   output logic [CNT_W-1:0] end_ent,
   output logic             bad_cfg
);

   localparam int unsigned MAX_FIELD = (1 << LVL_W) - 1;

   if (UNIT == 0) begin : g_bad_unit
      $error("dfp_thresh: UNIT must be non-zero");
   end
   if (MAX_FIELD * UNIT > DEPTH) begin : g_bad_range
      $error("dfp_thresh: scaled threshold exceeds FIFO depth");
   end

   if (dfp_pkg::is_pow2(UNIT)) begin : g_shift
      localparam int unsigned SH = dfp_pkg::log2_exact(UNIT);
      always_comb begin
         start_ent = CNT_W'(start_lvl) << SH;
         end_ent   = CNT_W'(end_lvl) << SH;
      end
   end else begin : g_mult
      always_comb begin
         start_ent = CNT_W'(start_lvl) * CNT_W'(UNIT);
         end_ent   = CNT_W'(end_lvl) * CNT_W'(UNIT);
      end
   end

   always_comb begin
      bad_cfg = (start_lvl == '0) || (end_lvl == '0) || (start_lvl >= end_lvl);
   end

   always_comb begin
      if (!bad_cfg) begin
         a_r7_order_ok: assert (start_ent < end_ent);
      end
   end

endmodule

// File: rtl/dfp_urgency.sv
module dfp_urgency #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bad_cfg,
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] start_ent,
   input  logic [CNT_W-1:0] end_ent,
   output logic             urgent
);
   import dfp_pkg::*;

   urg_state_e st_q;
   urg_state_e st_d;

   always_comb begin
      st_d = st_q;
      if (!en || bad_cfg) begin
         st_d = URG_OFF;
      end else begin
         case (st_q)
            URG_OFF: if (level <= start_ent) st_d = URG_ON;
            URG_ON:  if (level >= end_ent)   st_d = URG_OFF;
            default: st_d = URG_OFF;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= URG_OFF;
      else        st_q <= st_d;
   end

   assign urgent = (st_q == URG_ON);

   a_r5_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!urgent && en && !bad_cfg && level <= start_ent) |=> urgent);

   a_r6_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (urgent && en && !bad_cfg && level >= end_ent) |=> !urgent);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !bad_cfg && level > start_ent && level < end_ent) |=> $stable(urgent));

   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !urgent);

endmodule

// File: rtl/dfp_prio_ctrl.sv
module dfp_prio_ctrl #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned LVL_W = 4,
   parameter int unsigned UNIT  = 4,
   parameter int unsigned BURST = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic             push,
   input  logic             pop,
   input  logic [LVL_W-1:0] start_lvl,
   input  logic [LVL_W-1:0] end_lvl,
   output logic             req,
   output logic             high_pri,
   output logic             cfg_err
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] ROOM_LIM = CNT_W'(DEPTH - BURST);

   if (BURST == 0 || BURST >= DEPTH) begin : g_bad_burst
      $error("dfp_prio_ctrl: BURST must be in 1..DEPTH-1");
   end

   logic [CNT_W-1:0] level;
   logic [CNT_W-1:0] start_ent;
   logic [CNT_W-1:0] end_ent;
   logic             bad_cfg;
   logic             urgent;

   dfp_level_ctr #(.DEPTH(DEPTH)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (load_en),
      .push  (push),
      .pop   (pop),
      .level (level)
   );

   dfp_thresh #(.LVL_W(LVL_W), .UNIT(UNIT), .DEPTH(DEPTH)) u_thr (
      .start_lvl (start_lvl),
      .end_lvl   (end_lvl),
      .start_ent (start_ent),
      .end_ent   (end_ent),
      .bad_cfg   (bad_cfg)
   );

   dfp_urgency #(.CNT_W(CNT_W)) u_urg (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (load_en),
      .bad_cfg   (bad_cfg),
      .level     (level),
      .start_ent (start_ent),
      .end_ent   (end_ent),
      .urgent    (urgent)
   );

   always_comb begin
      cfg_err  = bad_cfg;
      high_pri = urgent && load_en && !bad_cfg;
      req      = load_en && (high_pri || (level < ROOM_LIM));
   end

   a_r7_err_no_hp: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !high_pri);

   a_r4_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |-> !req);

   a_r4_hp_implies_req: assert property (@(posedge clk) disable iff (!rst_n)
      high_pri |-> req);

endmodule

// File: tb/dfp_prio_ctrl_bench.sv
module dfp_prio_ctrl_bench;

   localparam int CLK_P = 10;

   typedef struct {
      bit    req;
      bit    hp;
      bit    err;
      string tag;
   } exp_t;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       load_en = 0;
   logic       push = 0;
   logic       pop = 0;
   logic [3:0] start_lvl = 4'd4;
   logic [3:0] end_lvl = 4'd8;
   logic       req, high_pri, cfg_err;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   int m_cnt = 0;
   bit m_hp = 0;
   exp_t sb[$];

   always #(CLK_P/2) clk = ~clk;

   dfp_prio_ctrl u_dfp_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .push(push), .pop(pop),
      .start_lvl(start_lvl), .end_lvl(end_lvl),
      .req(req), .high_pri(high_pri), .cfg_err(cfg_err)
   );

   function automatic bit model_err();
      return (start_lvl == 0) || (end_lvl == 0) || (start_lvl >= end_lvl);
   endfunction

   task automatic check3(bit er, bit eh, bit ee, string tag);
      checks++;
      if (req !== er || high_pri !== eh || cfg_err !== ee) begin
         fails++;
         $display("FAIL %s: req/hp/err actual=%b%b%b expected=%b%b%b",
                  tag, req, high_pri, cfg_err, er, eh, ee);
      end
   endtask

   // driver: called at a falling edge; applies stimulus for one cycle
   task automatic step(bit en, bit pu, bit po, string tag);
      bit   err, nhp;
      exp_t e;
      load_en = en; push = pu; pop = po;
      @(posedge clk);
      err = model_err();
      if (!en || err) nhp = 0;
      else if (m_hp) nhp = !(m_cnt >= 4 * end_lvl);
      else nhp = (m_cnt <= 4 * start_lvl);
      if (en) begin
         if (pu && !po && m_cnt < 64) m_cnt++;
         else if (po && !pu && m_cnt > 0) m_cnt--;
         else if (pu && po && m_cnt == 0) m_cnt++;
         else if (pu && po && m_cnt == 64) m_cnt--;
      end
      m_hp = nhp;
      e.err = err;
      e.hp  = m_hp && en && !err;
      e.req = en && (e.hp || m_cnt < 60);
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
   endtask

   task automatic repeat_step(int n, bit en, bit pu, bit po, string tag);
      for (int i = 0; i < n; i++) step(en, pu, po, tag);
   endtask

   // monitor: compares design outputs against the scoreboard
   always @(posedge clk) begin
      #(CLK_P/4);
      while (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check3(e.req, e.hp, e.err, e.tag);
      end
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check3(0, 0, 0, "R1 reset outputs");
      rst_n = 1;
      // R1: count starts at zero: with enable, room available and urgent at once
      step(1, 0, 0, "R1 R5 count zero after reset");
      step(1, 0, 0, "R5 urgent at empty");
      repeat_step(40, 1, 1, 0, "R2 R6 fill past end level");
      repeat_step(10, 1, 0, 1, "R6 hysteresis hold off");
      repeat_step(20, 1, 0, 1, "R5 drain to start level");
      repeat_step(20, 1, 1, 0, "R6 hysteresis hold on");
      repeat_step(5, 0, 1, 0, "R8 disabled pushes ignored");
      repeat_step(3, 0, 0, 1, "R8 disabled pops ignored");
      repeat_step(2, 1, 0, 0, "R8 re-enable non-urgent");
      repeat_step(36, 1, 1, 0, "R2 R4 fill to full");
      repeat_step(3, 1, 1, 0, "R3 push at full ignored");
      repeat_step(2, 1, 1, 1, "R2 push+pop at full");
      repeat_step(2, 1, 1, 1, "R2 push+pop mid");
      repeat_step(63, 1, 0, 1, "R2 R5 drain to empty");
      repeat_step(3, 1, 0, 1, "R3 pop at empty ignored");
      step(1, 1, 1, "R2 push+pop at empty");
      repeat_step(2, 1, 0, 0, "R5 urgent low level");
      start_lvl = 4'd8; end_lvl = 4'd8;
      repeat_step(2, 1, 0, 0, "R7 start equals end");
      start_lvl = 4'd0; end_lvl = 4'd8;
      repeat_step(2, 1, 0, 0, "R7 start zero");
      start_lvl = 4'd4; end_lvl = 4'd0;
      repeat_step(2, 1, 0, 0, "R7 end zero");
      start_lvl = 4'd9; end_lvl = 4'd3;
      repeat_step(2, 1, 0, 0, "R7 start above end");
      start_lvl = 4'd1; end_lvl = 4'd15;
      repeat_step(3, 1, 0, 0, "R5 valid again");
      repeat_step(62, 1, 1, 0, "R6 R4 fill to widest end level");
      repeat_step(2, 1, 0, 0, "R4 R6 idle near full");
      repeat (2) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule